// File: doc/BRIEF.md
# Timer Counter with Compare

This block is an 8-bit up-counter that advances once for each count-enable pulse from an external clock-select unit. It has a compare register and two waveform modes. In the free-running mode the count climbs to its all-ones value and wraps to zero. In the clear-on-match mode the count returns to zero on the tick after it equals the compare register, so the compare value sets the period. Software can write the count and the compare register at any time. Direct write strobes stand in for a bus.

Two sticky flags record events. The overflow flag records a pass from all-ones to zero, and the compare flag records a tick taken while the count equals the compare value. Each flag raises its own interrupt line when its enable input is high. A flag clears on an acknowledge pulse or on a write-one-to-clear strobe. In the clear-on-match mode a compare output pin can toggle, go low or go high on each match. An output-enable line shows whether the pin is connected.

Top module: `tmr8_cmp`

## Requirements
- R1: After reset, count, compare value, both flags, both interrupt lines, oc_pin and oc_oe are all 0.
- R2: With no count write, a cycle with tick=1 adds one to the count (modulo 256), unless R4 applies. A cycle with tick=0 leaves the count unchanged.
- R3: In wave_mode 2'b00, 2'b10 and 2'b11 the count runs from 8'hFF to 8'h00 on the next tick.
- R4: In wave_mode 2'b01, a tick taken while count equals the compare value loads 0 into the count.
- R5: A tick taken at count 8'hFF with no count write sets ovf_flag on the following cycle, in any mode.
- R6: A tick taken while count equals the compare value, with no count write, sets cmp_flag on the following cycle, in any mode.
- R7: ovf_irq equals ovf_flag AND ovf_ie. cmp_irq equals cmp_flag AND cmp_ie.
- R8: A flag clears when either of two things happens: a pulse on its acknowledge input (ovf_ack or cmp_ack), or flag_clr_we=1 with its bit set in flag_clr_data (bit 0 for overflow, bit 1 for compare). If a set event happens in the same cycle, the set wins.
- R9: cnt_we=1 loads cnt_wdata on the next edge, whatever tick and mode are. That cycle produces neither a match event nor an overflow event.
- R10: In wave_mode 2'b01, a match event applies the pin_act encoding to oc_pin: 00 leaves it unchanged, 01 toggles it, 10 drives it to 0, 11 drives it to 1. oc_oe is 1 exactly when wave_mode is 2'b01 and pin_act is not 00. In other modes oc_pin does not change.
- R11: cmp_we=1 loads cmp_wdata into the compare register on the next edge, and the new value sets the clear-on-match period from then on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick | input | 1 | Count-enable pulse from the clock-select unit |
| cnt_we | input | 1 | Count write strobe |
| cnt_wdata | input | 8 | Value to load into the count |
| cmp_we | input | 1 | Compare register write strobe |
| cmp_wdata | input | 8 | Value to load into the compare register |
| wave_mode | input | 2 | 01 selects clear-on-match; every other value selects free-running |
| pin_act | input | 2 | Action taken on the compare pin at a match |
| ovf_ie | input | 1 | Overflow interrupt enable |
| cmp_ie | input | 1 | Compare interrupt enable |
| ovf_ack | input | 1 | Overflow interrupt acknowledge |
| cmp_ack | input | 1 | Compare interrupt acknowledge |
| flag_clr_we | input | 1 | Write-one-to-clear strobe for the flags |
| flag_clr_data | input | 2 | Bit 0 clears overflow, bit 1 clears compare |
| count | output | 8 | Current count |
| cmp_val | output | 8 | Current compare register |
| ovf_flag | output | 1 | Overflow flag |
| cmp_flag | output | 1 | Compare flag |
| ovf_irq | output | 1 | Overflow interrupt request |
| cmp_irq | output | 1 | Compare interrupt request |
| oc_pin | output | 1 | Compare output pin level |
| oc_oe | output | 1 | Compare output pin enable |

## Verification
Collisions are the hardest cases to reach from the ports. One is a count write in the very cycle where a tick would match or overflow. Another is an acknowledge or clear strobe that lands in the same cycle as a new set event. Directed sequences set up each collision exactly: they load the count to equal the compare value, or to 8'hFE, and then pulse the strobes together. A long random run follows. It occasionally writes the count near 8'hFF or onto the compare value and changes the mode, so both wrap paths and the pin actions recur many times.

// File: rtl/tmr8_pkg.sv
package tmr8_pkg;

  typedef enum logic [1:0] {
    ACT_KEEP = 2'b00,
    ACT_TOG  = 2'b01,
    ACT_LOW  = 2'b10,
    ACT_HIGH = 2'b11
  } pin_act_e;

  localparam logic [1:0] MODE_CLR = 2'b01;

  localparam int FLAG_OVF = 0;
  localparam int FLAG_CMP = 1;
  localparam int NFLAG    = 2;

  function automatic logic is_clr_mode(input logic [1:0] mode);
    return mode == MODE_CLR;
  endfunction

  function automatic logic pin_next(input pin_act_e act, input logic cur);
    case (act)
      ACT_TOG:  return ~cur;
      ACT_LOW:  return 1'b0;
      ACT_HIGH: return 1'b1;
      default:  return cur;
    endcase
  endfunction

endpackage

// File: rtl/tmr8_core.sv
module tmr8_core #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic         cnt_we,
  input  logic [W-1:0] cnt_wdata,
  input  logic         cmp_we,
  input  logic [W-1:0] cmp_wdata,
  input  logic         clr_mode,
  output logic [W-1:0] count,
  output logic [W-1:0] cmp_val,
  output logic         match_ev,
  output logic         ovf_ev
);

  localparam logic [W-1:0] TOPV = {W{1'b1}};

  function automatic logic [W-1:0] step(input logic [W-1:0] cur,
                                        input logic [W-1:0] cmpv,
                                        input logic         clr);
    if (clr && cur == cmpv) return '0;
    return cur + 1'b1;
  endfunction

  logic [W-1:0] cnt_q, cmp_q, cnt_d;
  logic         live_tick;

  assign live_tick = tick & ~cnt_we;
  assign match_ev  = live_tick & (cnt_q == cmp_q);
  assign ovf_ev    = live_tick & (cnt_q == TOPV);

  always_comb begin
    cnt_d = cnt_q;
    if (cnt_we)    cnt_d = cnt_wdata;
    else if (tick) cnt_d = step(cnt_q, cmp_q, clr_mode);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      cmp_q <= '0;
    end else begin
      cnt_q <= cnt_d;
      if (cmp_we) cmp_q <= cmp_wdata;
    end
  end

  assign count   = cnt_q;
  assign cmp_val = cmp_q;

endmodule

// File: rtl/tmr8_flags.sv
module tmr8_flags #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_ev,
  input  logic [N-1:0] clr_ev,
  input  logic [N-1:0] irq_en,
  output logic [N-1:0] flag,
  output logic [N-1:0] irq
);

  for (genvar i = 0; i < N; i++) begin : g_flag
    logic f_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) f_q <= 1'b0;
      else        f_q <= set_ev[i] | (f_q & ~clr_ev[i]);
    end
    assign flag[i] = f_q;
    assign irq[i]  = f_q & irq_en[i];
  end

endmodule

// File: rtl/tmr8_ocu.sv
module tmr8_ocu
  import tmr8_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       match_ev,
  input  logic       clr_mode,
  input  logic [1:0] pin_act,
  output logic       oc_pin,
  output logic       oc_oe
);

  pin_act_e act;
  logic     pin_q;

  assign act = pin_act_e'(pin_act);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     pin_q <= 1'b0;
    else if (match_ev && clr_mode)  pin_q <= pin_next(act, pin_q);
  end

  assign oc_pin = pin_q;
  assign oc_oe  = clr_mode & (act != ACT_KEEP);

endmodule

// File: rtl/tmr8_cmp.sv
module tmr8_cmp
  import tmr8_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic         cnt_we,
  input  logic [W-1:0] cnt_wdata,
  input  logic         cmp_we,
  input  logic [W-1:0] cmp_wdata,
  input  logic [1:0]   wave_mode,
  input  logic [1:0]   pin_act,
  input  logic         ovf_ie,
  input  logic         cmp_ie,
  input  logic         ovf_ack,
  input  logic         cmp_ack,
  input  logic         flag_clr_we,
  input  logic [1:0]   flag_clr_data,
  output logic [W-1:0] count,
  output logic [W-1:0] cmp_val,
  output logic         ovf_flag,
  output logic         cmp_flag,
  output logic         ovf_irq,
  output logic         cmp_irq,
  output logic         oc_pin,
  output logic         oc_oe
);

  logic             clr_mode;
  logic             match_ev;
  logic             ovf_ev;
  logic [NFLAG-1:0] set_ev, clr_ev, irq_en, flag, irq;

  assign clr_mode = is_clr_mode(wave_mode);

  tmr8_core #(.W(W)) u_core (
    .clk(clk), .rst_n(rst_n), .tick(tick),
    .cnt_we(cnt_we), .cnt_wdata(cnt_wdata),
    .cmp_we(cmp_we), .cmp_wdata(cmp_wdata),
    .clr_mode(clr_mode), .count(count), .cmp_val(cmp_val),
    .match_ev(match_ev), .ovf_ev(ovf_ev)
  );

  assign set_ev[FLAG_OVF] = ovf_ev;
  assign set_ev[FLAG_CMP] = match_ev;
  assign clr_ev[FLAG_OVF] = ovf_ack | (flag_clr_we & flag_clr_data[FLAG_OVF]);
  assign clr_ev[FLAG_CMP] = cmp_ack | (flag_clr_we & flag_clr_data[FLAG_CMP]);
  assign irq_en[FLAG_OVF] = ovf_ie;
  assign irq_en[FLAG_CMP] = cmp_ie;

  tmr8_flags #(.N(NFLAG)) u_flags (
    .clk(clk), .rst_n(rst_n), .set_ev(set_ev), .clr_ev(clr_ev),
    .irq_en(irq_en), .flag(flag), .irq(irq)
  );

  assign ovf_flag = flag[FLAG_OVF];
  assign cmp_flag = flag[FLAG_CMP];
  assign ovf_irq  = irq[FLAG_OVF];
  assign cmp_irq  = irq[FLAG_CMP];

  tmr8_ocu u_ocu (
    .clk(clk), .rst_n(rst_n), .match_ev(match_ev), .clr_mode(clr_mode),
    .pin_act(pin_act), .oc_pin(oc_pin), .oc_oe(oc_oe)
  );

endmodule

// File: rtl/tmr8_cmp_chk.sv
module tmr8_cmp_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         tick,
  input logic         cnt_we,
  input logic [W-1:0] cnt_wdata,
  input logic [1:0]   wave_mode,
  input logic [1:0]   pin_act,
  input logic [W-1:0] count,
  input logic [W-1:0] cmp_val,
  input logic         ovf_flag,
  input logic         ovf_irq,
  input logic         cmp_flag,
  input logic         oc_pin,
  input logic         match_ev
);

  logic at_clear;
  assign at_clear = (wave_mode == 2'b01) && (count == cmp_val);

  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !cnt_we) |=> $stable(count));

  p_inc_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !cnt_we && !at_clear) |=> count == W'($past(count) + 1'b1));

  p_clr_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !cnt_we && at_clear) |=> count == '0);

  p_wr_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_we |=> count == $past(cnt_wdata));

  p_nomatch_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_we |-> !match_ev);

  p_ovf_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !cnt_we && count == {W{1'b1}}) |=> ovf_flag);

  p_cmp_r6: assert property (@(posedge clk) disable iff (!rst_n)
    match_ev |=> cmp_flag);

  p_irq_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !ovf_flag |-> !ovf_irq);

  p_pin_hi_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (match_ev && wave_mode == 2'b01 && pin_act == 2'b11) |=> oc_pin);

  p_pin_lo_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (match_ev && wave_mode == 2'b01 && pin_act == 2'b10) |=> !oc_pin);

  p_pin_free_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (wave_mode != 2'b01) |=> $stable(oc_pin));

endmodule

bind tmr8_cmp tmr8_cmp_chk #(.W(W)) u_chk (.*);

// File: tb/tmr8_cmp_tb.sv
`timescale 1ns/1ps
module tmr8_cmp_tb;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 0, cnt_we = 0, cmp_we = 0;
  logic [7:0] cnt_wdata = 0, cmp_wdata = 0;
  logic [1:0] wave_mode = 0, pin_act = 0, flag_clr_data = 0;
  logic       ovf_ie = 0, cmp_ie = 0, ovf_ack = 0, cmp_ack = 0, flag_clr_we = 0;
  logic [7:0] count, cmp_val;
  logic       ovf_flag, cmp_flag, ovf_irq, cmp_irq, oc_pin, oc_oe;

  always #2 clk = ~clk;

  tmr8_cmp u_dut (.*);

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  logic [7:0] m_cnt = 0, m_cmp = 0;
  logic       m_ovf = 0, m_cf = 0, m_pin = 0;
  string      t_cnt = "R1", t_ovf = "R1", t_cf = "R1", t_cmp = "R1", t_pin = "R1";

  task automatic chk(string tag, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  function automatic logic pin_rule(logic [1:0] a, logic cur);
    if (a == 2'b01) return ~cur;
    if (a == 2'b10) return 1'b0;
    if (a == 2'b11) return 1'b1;
    return cur;
  endfunction

  task automatic idle();
    tick = 0; cnt_we = 0; cmp_we = 0; ovf_ack = 0; cmp_ack = 0; flag_clr_we = 0;
  endtask

  task automatic check_all();
    logic cm;
    cm = (wave_mode == 2'b01);
    chk(t_cnt, "count", count, m_cnt);
    chk(t_cmp, "cmp_val", cmp_val, m_cmp);
    chk(t_ovf, "ovf_flag", ovf_flag, m_ovf);
    chk(t_cf, "cmp_flag", cmp_flag, m_cf);
    chk("R7", "ovf_irq", ovf_irq, m_ovf & ovf_ie);
    chk("R7", "cmp_irq", cmp_irq, m_cf & cmp_ie);
    chk(t_pin, "oc_pin", oc_pin, m_pin);
    chk("R10", "oc_oe", oc_oe, cm && pin_act != 2'b00);
  endtask

  task automatic cycle();
    logic cm, eq, mt, ov, c0, c1;
    logic [7:0] n_cnt;
    cm = (wave_mode == 2'b01);
    eq = (m_cnt == m_cmp);
    mt = tick && !cnt_we && eq;
    ov = tick && !cnt_we && (m_cnt == 8'hFF);
    if (cnt_we) begin n_cnt = cnt_wdata; t_cnt = "R9"; end
    else if (tick && cm && eq) begin n_cnt = 8'h00; t_cnt = "R4"; end
    else if (tick) begin n_cnt = m_cnt + 8'd1; t_cnt = (m_cnt == 8'hFF) ? "R3" : "R2"; end
    else begin n_cnt = m_cnt; t_cnt = "R2"; end
    c0 = ovf_ack | (flag_clr_we & flag_clr_data[0]);
    c1 = cmp_ack | (flag_clr_we & flag_clr_data[1]);
    t_ovf = c0 ? "R8" : (cnt_we ? "R9" : "R5");
    t_cf  = c1 ? "R8" : (cnt_we ? "R9" : "R6");
    t_cmp = "R11";
    t_pin = "R10";
    if (cmp_we) m_cmp = cmp_wdata;
    m_ovf = ov | (m_ovf & ~c0);
    m_cf  = mt | (m_cf & ~c1);
    if (mt && cm) m_pin = pin_rule(pin_act, m_pin);
    m_cnt = n_cnt;
    @(posedge clk);
    @(negedge clk);
    check_all();
    idle();
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    int unsigned seed;
    seed = 32'd1234;
    void'($urandom(seed));
    repeat (3) @(negedge clk);
    check_all();                       // R1 reset state
    rst_n = 1'b1;
    @(negedge clk);
    check_all();

    // R3/R5: wrap in normal mode, with irq enabled (R7)
    ovf_ie = 1; cnt_we = 1; cnt_wdata = 8'hFE; cycle();
    tick = 1; cycle();
    tick = 1; cycle();
    chk("R5", "ovf after wrap", ovf_flag, 1);
    // R8: ack clears
    ovf_ack = 1; cycle();
    chk("R8", "ovf cleared by ack", ovf_flag, 0);

    // R11/R4: compare 3 in clear mode, period 4 ticks
    wave_mode = 2'b01; pin_act = 2'b01; cmp_ie = 1;
    cmp_we = 1; cmp_wdata = 8'd3; cnt_we = 1; cnt_wdata = 8'd0; cycle();
    for (int i = 0; i < 4; i++) begin tick = 1; cycle(); end
    chk("R11", "period 4 back to 0", count, 0);
    chk("R10", "toggle pin", oc_pin, 1);

    // R9: write in a cycle that would match
    cnt_we = 1; cnt_wdata = 8'd3; cycle();
    flag_clr_we = 1; flag_clr_data = 2'b10; cycle();
    chk("R8", "cmp cleared by w1c", cmp_flag, 0);
    tick = 1; cnt_we = 1; cnt_wdata = 8'd3; cycle();
    chk("R9", "no match on write cycle", cmp_flag, 0);
    // R8: set wins over ack in the same cycle
    tick = 1; cmp_ack = 1; cycle();
    chk("R8", "set beats ack", cmp_flag, 1);
    // R10: high, low actions
    pin_act = 2'b10; cnt_we = 1; cnt_wdata = 8'd3; cycle();
    tick = 1; cycle();
    chk("R10", "drive low", oc_pin, 0);
    pin_act = 2'b11; cnt_we = 1; cnt_wdata = 8'd3; cycle();
    tick = 1; cycle();
    chk("R10", "drive high", oc_pin, 1);
    // R3: mode 11 behaves as free-running
    wave_mode = 2'b11; cnt_we = 1; cnt_wdata = 8'd3; cycle();
    tick = 1; cycle();
    chk("R3", "mode 11 no clear", count, 4);

    for (int i = 0; i < 5000; i++) begin
      int unsigned r;
      r = $urandom % 100;
      if (r < 2) wave_mode = ($urandom % 2) ? 2'b01 : 2'($urandom % 4);
      if ($urandom % 100 < 3) pin_act = 2'($urandom % 4);
      if ($urandom % 100 < 3) begin ovf_ie = 1'($urandom); cmp_ie = 1'($urandom); end
      tick = ($urandom % 100) < 70;
      if ($urandom % 100 < 5) begin
        cnt_we = 1;
        case ($urandom % 3)
          0: cnt_wdata = 8'hFD + 8'($urandom % 3);
          1: cnt_wdata = m_cmp;
          default: cnt_wdata = 8'($urandom);
        endcase
      end
      if ($urandom % 100 < 3) begin cmp_we = 1; cmp_wdata = 8'($urandom); end
      ovf_ack = ($urandom % 100) < 5;
      cmp_ack = ($urandom % 100) < 5;
      if ($urandom % 100 < 5) begin flag_clr_we = 1; flag_clr_data = 2'($urandom); end
      cycle();
    end

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule